// File: doc/BRIEF.md
# Per-Opcode Taint Filter Table

This block decides, within the cycle an instruction is examined, whether the instruction's output taint state can be worked out without the full propagation lookup. Each opcode has a 2-bit policy in a table of 256 entries. A lookup presents an opcode, the taint states of two register sources with their register indices, and the taint state of the memory operand. When the policy covers the case, the block reports a hit and the resolved output state. When it does not, the block reports a miss, and the instruction goes on to the slower response-cache path.

Two shortcuts exist. The zero shortcut applies when every input is the all-zero (safe) state, and the result is zero. The unary shortcut applies when exactly one input is nonzero, and the result is that input. Register 0 always counts as clean. The lookup path has no register in it, so instructions that depend on each other and retire in the same cycle can be resolved back to back.

System software saves and restores the whole table as sixteen 32-bit words when it switches processes.

Top module: `taint_filter_table`

## Requirements
- R1: After reset every policy entry reads as 00, so every valid lookup misses and every software word reads as zero.
- R2: A software write to word index w replaces the policies of opcodes 16*w to 16*w+15. The policy of opcode 16*w+k sits in bits [2k+1:2k] of the word. The new policy takes effect at the next clock edge.
- R3: sw_rdata always shows the current contents of the word selected by sw_addr, with no latency. A word read and then written back reproduces the same lookup behaviour.
- R4: Policy 01 (zero only): when all three effective inputs are zero, the lookup hits with output 0. When any effective input is nonzero, it misses.
- R5: Policy 10 (zero and unary): when all inputs are zero, the lookup hits with output 0. When exactly one effective input is nonzero, it hits and outputs that input's state. When two or more are nonzero, it misses.
- R6: Policies 00 and 11 resolve nothing. Every valid lookup under either policy misses, even with all-zero inputs.
- R7: A register source whose index is 0 counts as taint state zero, whatever taint value is presented for it.
- R8: When lk_valid is high, exactly one of lk_hit and lk_miss is high. When lk_valid is low, both are low. lk_taint is zero whenever the lookup does not hit.
- R9: The lookup result is combinational in the same cycle. A software write made in the same cycle as a lookup does not change that lookup's result; it affects lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_opcode | input | 8 | Opcode of the instruction |
| lk_src_a_reg | input | 5 | Register index of the first source |
| lk_src_a_taint | input | 2 | Taint state of the first source |
| lk_src_b_reg | input | 5 | Register index of the second source |
| lk_src_b_taint | input | 2 | Taint state of the second source |
| lk_mem_taint | input | 2 | Taint state of the memory operand (zero if none) |
| lk_hit | output | 1 | Lookup resolved by the table |
| lk_miss | output | 1 | Lookup needs the full propagation path |
| lk_taint | output | 2 | Resolved output state, zero unless hit |
| sw_wr_en | input | 1 | Software word write strobe |
| sw_addr | input | 4 | Software word index |
| sw_wdata | input | 32 | Software write data, 16 policies |
| sw_rdata | output | 32 | Software read data for sw_addr |

## Verification
The assertions check on every cycle that hit and miss are mutually exclusive, that an unresolved lookup carries a zero state, that all-zero inputs resolve under the two shortcut policies, that a nonzero result only appears under the unary policy, that register 0 is forced clean, and that a written word reads back after the edge. The bench scenarios show what a cycle-local property cannot. They show the bit position of each opcode's policy inside a word, the exact value passed through in the unary case, the misses for two or three nonzero inputs, the reserved policy 11, the old policy applying to a lookup made in the same cycle as the write, and a full save-and-restore round trip.

// File: rtl/tft_pkg.sv
package tft_pkg;

  typedef enum logic [1:0] {
    POL_NONE  = 2'b00,
    POL_ZERO  = 2'b01,
    POL_UNARY = 2'b10,
    POL_RSVD  = 2'b11
  } tft_pol_e;

  function automatic logic pol_zero_ok(input logic [1:0] pol);
    return (pol == POL_ZERO) || (pol == POL_UNARY);
  endfunction

  function automatic logic pol_unary_ok(input logic [1:0] pol);
    return pol == POL_UNARY;
  endfunction

endpackage

// File: rtl/tft_store.sv
module tft_store #(
  parameter int OPC_W  = 8,
  parameter int POL_W  = 2,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OPC_W-1:0]    opcode,
  output logic [POL_W-1:0]    pol,
  input  logic                wr_en,
  input  logic [OPC_W-$clog2(WORD_W/POL_W)-1:0] addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata
);
  localparam int EPW    = WORD_W / POL_W;
  localparam int LANE_W = $clog2(EPW);
  localparam int IDX_W  = OPC_W - LANE_W;
  localparam int NWORDS = 1 << IDX_W;

  logic [WORD_W-1:0] words [NWORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWORDS; w++) words[w] <= '0;
    end else if (wr_en) begin
      words[addr] <= wdata;
    end
  end

  logic [IDX_W-1:0]  opc_word;
  logic [LANE_W-1:0] opc_lane;
  logic [WORD_W-1:0] sel_word;

  assign opc_word = opcode[OPC_W-1:LANE_W];
  assign opc_lane = opcode[LANE_W-1:0];
  assign sel_word = words[opc_word];
  assign pol      = sel_word[opc_lane*POL_W +: POL_W];
  assign rdata    = words[addr];
endmodule

// File: rtl/tft_resolve.sv
module tft_resolve #(
  parameter int TAINT_W = 2,
  parameter int NSRC    = 3
) (
  input  logic                    valid,
  input  logic [1:0]              pol,
  input  logic [NSRC*TAINT_W-1:0] srcs,
  output logic [$clog2(NSRC+1)-1:0] nz_count,
  output logic                    hit,
  output logic                    miss,
  output logic [TAINT_W-1:0]      out_taint
);
  import tft_pkg::*;
  localparam int CNT_W = $clog2(NSRC + 1);

  function automatic logic [CNT_W-1:0] count_nz(input logic [NSRC*TAINT_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NSRC; i++)
      if (v[i*TAINT_W +: TAINT_W] != '0) c = c + 1'b1;
    return c;
  endfunction

  function automatic logic [TAINT_W-1:0] merge_all(input logic [NSRC*TAINT_W-1:0] v);
    logic [TAINT_W-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m = m | v[i*TAINT_W +: TAINT_W];
    return m;
  endfunction

  logic zero_case, unary_case, resolved;

  assign nz_count   = count_nz(srcs);
  assign zero_case  = (nz_count == '0) && pol_zero_ok(pol);
  assign unary_case = (nz_count == CNT_W'(1)) && pol_unary_ok(pol);
  assign resolved   = zero_case || unary_case;
  assign hit        = valid && resolved;
  assign miss       = valid && !resolved;
  assign out_taint  = (valid && unary_case) ? merge_all(srcs) : '0;
endmodule

// File: rtl/taint_filter_table.sv
module taint_filter_table #(
  parameter int OPC_W   = 8,
  parameter int TAINT_W = 2,
  parameter int REG_W   = 5,
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [OPC_W-1:0]   lk_opcode,
  input  logic [REG_W-1:0]   lk_src_a_reg,
  input  logic [TAINT_W-1:0] lk_src_a_taint,
  input  logic [REG_W-1:0]   lk_src_b_reg,
  input  logic [TAINT_W-1:0] lk_src_b_taint,
  input  logic [TAINT_W-1:0] lk_mem_taint,
  output logic               lk_hit,
  output logic               lk_miss,
  output logic [TAINT_W-1:0] lk_taint,
  input  logic               sw_wr_en,
  input  logic [ADDR_W-1:0]  sw_addr,
  input  logic [WORD_W-1:0]  sw_wdata,
  output logic [WORD_W-1:0]  sw_rdata
);
  localparam int POL_W = 2;
  localparam int NREG  = 2;
  localparam int NSRC  = NREG + 1;
  localparam int CNT_W = $clog2(NSRC + 1);

  logic [NREG*REG_W-1:0]   reg_idx;
  logic [NREG*TAINT_W-1:0] reg_taint;
  logic [NSRC*TAINT_W-1:0] eff_srcs;
  logic [POL_W-1:0]        lk_pol;
  logic [CNT_W-1:0]        nz_count;

  assign reg_idx   = {lk_src_b_reg, lk_src_a_reg};
  assign reg_taint = {lk_src_b_taint, lk_src_a_taint};

  for (genvar g = 0; g < NREG; g++) begin : g_regmask
    assign eff_srcs[g*TAINT_W +: TAINT_W] =
      (reg_idx[g*REG_W +: REG_W] == '0) ? '0 : reg_taint[g*TAINT_W +: TAINT_W];
  end
  assign eff_srcs[NREG*TAINT_W +: TAINT_W] = lk_mem_taint;

  tft_store #(.OPC_W(OPC_W), .POL_W(POL_W), .WORD_W(WORD_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (lk_opcode),
    .pol    (lk_pol),
    .wr_en  (sw_wr_en),
    .addr   (sw_addr),
    .wdata  (sw_wdata),
    .rdata  (sw_rdata)
  );

  tft_resolve #(.TAINT_W(TAINT_W), .NSRC(NSRC)) u_resolve (
    .valid     (lk_valid),
    .pol       (lk_pol),
    .srcs      (eff_srcs),
    .nz_count  (nz_count),
    .hit       (lk_hit),
    .miss      (lk_miss),
    .out_taint (lk_taint)
  );
endmodule

// File: rtl/taint_filter_table_chk.sv
module taint_filter_table_chk #(
  parameter int TAINT_W = 2,
  parameter int REG_W   = 5,
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic               lk_miss,
  input logic [TAINT_W-1:0] lk_taint,
  input logic [1:0]         lk_pol,
  input logic [CNT_W-1:0]   nz_count,
  input logic [REG_W-1:0]   lk_src_a_reg,
  input logic [REG_W-1:0]   lk_src_b_reg,
  input logic [TAINT_W-1:0] lk_mem_taint,
  input logic               sw_wr_en,
  input logic [ADDR_W-1:0]  sw_addr,
  input logic [WORD_W-1:0]  sw_wdata,
  input logic [WORD_W-1:0]  sw_rdata
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != lk_miss)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss)); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_taint == '0)); // R8
  AST_ZERO_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && nz_count == '0 && (lk_pol == 2'b01 || lk_pol == 2'b10))
      |-> (lk_hit && lk_taint == '0)); // R4
  AST_NONZERO_UNARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_taint != '0) |-> (lk_pol == 2'b10)); // R5
  AST_NO_POLICY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && (lk_pol == 2'b00 || lk_pol == 2'b11)) |-> lk_miss); // R6
  AST_REG_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_pol == 2'b01 && lk_src_a_reg == '0 && lk_src_b_reg == '0
     && lk_mem_taint == '0) |-> lk_hit); // R7
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> ((sw_addr != $past(sw_addr)) || (sw_rdata == $past(sw_wdata)))); // R2
endmodule

bind taint_filter_table taint_filter_table_chk #(
  .TAINT_W(TAINT_W), .REG_W(REG_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_hit       (lk_hit),
  .lk_miss      (lk_miss),
  .lk_taint     (lk_taint),
  .lk_pol       (lk_pol),
  .nz_count     (nz_count),
  .lk_src_a_reg (lk_src_a_reg),
  .lk_src_b_reg (lk_src_b_reg),
  .lk_mem_taint (lk_mem_taint),
  .sw_wr_en     (sw_wr_en),
  .sw_addr      (sw_addr),
  .sw_wdata     (sw_wdata),
  .sw_rdata     (sw_rdata)
);

// File: tb/taint_filter_table_test.sv
module taint_filter_table_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [7:0]  lk_opcode = '0;
  logic [4:0]  lk_src_a_reg = '0, lk_src_b_reg = '0;
  logic [1:0]  lk_src_a_taint = '0, lk_src_b_taint = '0, lk_mem_taint = '0;
  logic        lk_hit, lk_miss;
  logic [1:0]  lk_taint;
  logic        sw_wr_en = 1'b0;
  logic [3:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [1:0] model [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  taint_filter_table uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_opcode(lk_opcode),
    .lk_src_a_reg(lk_src_a_reg), .lk_src_a_taint(lk_src_a_taint),
    .lk_src_b_reg(lk_src_b_reg), .lk_src_b_taint(lk_src_b_taint),
    .lk_mem_taint(lk_mem_taint), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_taint(lk_taint), .sw_wr_en(sw_wr_en), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Expected {hit, miss, taint} from the requirements.
  function automatic logic [3:0] expect_lk(input logic [1:0] pol,
      input logic [4:0] ra, input logic [1:0] ta,
      input logic [4:0] rb, input logic [1:0] tb, input logic [1:0] tm);
    logic [1:0] a, b;
    int nz;
    logic [1:0] only;
    a = (ra == 0) ? 2'd0 : ta;
    b = (rb == 0) ? 2'd0 : tb;
    nz = 0; only = 2'd0;
    if (a != 0) begin nz++; only = a; end
    if (b != 0) begin nz++; only = b; end
    if (tm != 0) begin nz++; only = tm; end
    if (nz == 0 && (pol == 2'b01 || pol == 2'b10)) return {2'b10, 2'd0};
    if (nz == 1 && pol == 2'b10) return {2'b10, only};
    return {2'b01, 2'd0};
  endfunction

  task automatic sw_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sw_wr_en = 1'b1; sw_addr = a; sw_wdata = d;
    @(negedge clk);
    sw_wr_en = 1'b0;
    for (int k = 0; k < 16; k++) model[a*16 + k] = d[2*k +: 2];
  endtask

  task automatic lookup(input string req, input logic [7:0] opc,
      input logic [4:0] ra, input logic [1:0] ta,
      input logic [4:0] rb, input logic [1:0] tb, input logic [1:0] tm);
    logic [3:0] e;
    @(negedge clk);
    lk_valid = 1'b1; lk_opcode = opc;
    lk_src_a_reg = ra; lk_src_a_taint = ta;
    lk_src_b_reg = rb; lk_src_b_taint = tb; lk_mem_taint = tm;
    #1;
    e = expect_lk(model[opc], ra, ta, rb, tb, tm);
    check(req, {28'd0, lk_hit, lk_miss, lk_taint}, {28'd0, e});
    lk_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      sw_addr = 4'(a); #1;
      check("R1 word zero", sw_rdata, 32'd0);
    end
    lookup("R1 miss after reset", 8'h00, 5'd0, 2'd0, 5'd0, 2'd0, 2'd0);
    lookup("R1 miss after reset", 8'hFF, 5'd1, 2'd1, 5'd2, 2'd0, 2'd0);
    @(negedge clk); #1;
    check("R8 idle quiet", {30'd0, lk_hit, lk_miss}, 32'd0);
  endtask

  task automatic t_layout();
    // word 3: lane 0 -> 01, lane 5 -> 10, lane 15 -> 11
    logic [31:0] d;
    d = 32'd0;
    d[1:0] = 2'b01; d[11:10] = 2'b10; d[31:30] = 2'b11;
    sw_write(4'd3, d);
    sw_addr = 4'd3; #1;
    check("R3 readback", sw_rdata, d);
    lookup("R2 lane0 zero", 8'h30, 5'd1, 2'd0, 5'd2, 2'd0, 2'd0);
    lookup("R2 lane5 unary", 8'h35, 5'd1, 2'd3, 5'd2, 2'd0, 2'd0);
    lookup("R2 neighbour untouched", 8'h34, 5'd1, 2'd0, 5'd2, 2'd0, 2'd0);
    lookup("R2 other word", 8'h25, 5'd1, 2'd0, 5'd2, 2'd0, 2'd0);
  endtask

  task automatic t_pol01();
    sw_write(4'd1, {16{2'b01}});
    lookup("R4 all zero hit", 8'h12, 5'd3, 2'd0, 5'd4, 2'd0, 2'd0);
    lookup("R4 one nonzero miss", 8'h12, 5'd3, 2'd1, 5'd4, 2'd0, 2'd0);
    lookup("R4 mem nonzero miss", 8'h17, 5'd3, 2'd0, 5'd4, 2'd0, 2'd2);
  endtask

  task automatic t_pol10();
    sw_write(4'd2, {16{2'b10}});
    lookup("R5 all zero hit", 8'h20, 5'd5, 2'd0, 5'd6, 2'd0, 2'd0);
    lookup("R5 unary a", 8'h21, 5'd5, 2'd2, 5'd6, 2'd0, 2'd0);
    lookup("R5 unary b", 8'h22, 5'd5, 2'd0, 5'd6, 2'd1, 2'd0);
    lookup("R5 unary mem", 8'h23, 5'd5, 2'd0, 5'd6, 2'd0, 2'd3);
    lookup("R5 two nonzero miss", 8'h24, 5'd5, 2'd1, 5'd6, 2'd2, 2'd0);
    lookup("R5 three nonzero miss", 8'h25, 5'd5, 2'd1, 5'd6, 2'd1, 2'd1);
  endtask

  task automatic t_pol_none();
    sw_write(4'd4, {16{2'b11}});
    lookup("R6 pol11 zero miss", 8'h40, 5'd1, 2'd0, 5'd2, 2'd0, 2'd0);
    lookup("R6 pol11 unary miss", 8'h4F, 5'd1, 2'd1, 5'd2, 2'd0, 2'd0);
    lookup("R6 pol00 zero miss", 8'h50, 5'd1, 2'd0, 5'd2, 2'd0, 2'd0);
  endtask

  task automatic t_reg0();
    lookup("R7 reg0 a masked pol01", 8'h12, 5'd0, 2'd3, 5'd4, 2'd0, 2'd0);
    lookup("R7 reg0 b masked pol01", 8'h12, 5'd3, 2'd0, 5'd0, 2'd2, 2'd0);
    lookup("R7 reg0 leaves unary", 8'h21, 5'd0, 2'd3, 5'd6, 2'd2, 2'd0);
  endtask

  task automatic t_same_cycle();
    // opcode 0x60: policy 00 now; write 10 and look up in the same cycle
    @(negedge clk);
    sw_wr_en = 1'b1; sw_addr = 4'd6; sw_wdata = {16{2'b10}};
    lk_valid = 1'b1; lk_opcode = 8'h60;
    lk_src_a_reg = 5'd1; lk_src_a_taint = 2'd1;
    lk_src_b_reg = 5'd2; lk_src_b_taint = 2'd0; lk_mem_taint = 2'd0;
    #1;
    check("R9 old policy same cycle", {29'd0, lk_hit, lk_miss, 1'b0}, {29'd0, 2'b01, 1'b0});
    @(negedge clk);
    sw_wr_en = 1'b0;
    #1;
    check("R9 new policy next cycle", {28'd0, lk_hit, lk_miss, lk_taint}, {28'd0, 2'b10, 2'd1});
    lk_valid = 1'b0;
    for (int k = 0; k < 16; k++) model[6*16 + k] = 2'b10;
  endtask

  task automatic t_restore();
    logic [31:0] saved;
    sw_addr = 4'd2; #1;
    saved = sw_rdata;
    check("R3 saved word", saved, {16{2'b10}});
    sw_write(4'd2, 32'd0);
    lookup("R3 cleared misses", 8'h21, 5'd5, 2'd2, 5'd6, 2'd0, 2'd0);
    sw_write(4'd2, saved);
    lookup("R3 restored unary", 8'h21, 5'd5, 2'd2, 5'd6, 2'd0, 2'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_pol01();
    t_pol10();
    t_pol_none();
    t_reg0();
    t_same_cycle();
    t_restore();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule